// File: doc/BRIEF.md
# Address Translation Cache with Page Invalidation

This block is a small fully associative store of recent page translations for an I/O address translation unit that uses 4 KB pages. A client presents a virtual page number on the lookup port. One clock later the block returns a registered hit flag, the physical page number and the eight attribute bits that the page entry carried. On a miss it returns zeros. A table walker that resolves a miss writes the result back through the fill port.

Stale translations are removed in two ways. The invalidate port takes a full virtual address and discards any entry whose page matches bits 31:12 of that address. The page offset bits play no part in the match. To clear a range, the controller writes one such address for each 4 KB step from the start of the range to its end. A flush strobe empties the whole store. The controller issues a flush after every page fault, so that no cached copy of an old directory or page entry survives.

A fill first reuses an entry that already holds the same page. If none does, it takes the lowest-numbered empty entry. If the store is full, it replaces the entry that a round-robin pointer selects.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is empty, `rsp_valid` is low, and a lookup of any page misses.
- R2: A lookup presented with `lk_valid` in cycle N answers in cycle N+1 with `rsp_valid` high. On a hit, `rsp_ppn` and `rsp_attr` are the filled values. On a miss, `rsp_hit`, `rsp_ppn` and `rsp_attr` are all zero.
- R3: A fill whose page is already cached overwrites that same entry, so one page never occupies two entries.
- R4: A fill takes the lowest-numbered empty entry if there is one. Only when every entry is valid does it replace the entry at the round-robin pointer. That pointer starts at 0, advances by one only on such a replacement, wraps after DEPTH-1, and returns to 0 on a flush.
- R5: An invalidate removes only the entry whose page equals `inv_vaddr[31:12]`. Bits 11:0 are ignored, and an address that matches no entry changes nothing.
- R6: `flush` empties every entry, and the flush takes effect by the next cycle.
- R7: When an invalidate and a fill name the same page in one cycle, the page is left uncached. When they name different pages, both take effect.
- R8: When `flush` and a fill arrive in the same cycle, the fill is dropped.
- R9: A lookup sees the contents as they stood before any fill, invalidate or flush presented in the same cycle.
- R10: Invalidating pages one by one, from the start address to the end address in 4 KB steps, removes every page of that range and leaves the pages on either side cached.
- R11: The attribute bits are returned unchanged. Bit 0 is the readable permission and bit 1 is the writable permission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to look up |
| rsp_valid | output | 1 | Lookup answer valid, one cycle after request |
| rsp_hit | output | 1 | Page was cached |
| rsp_ppn | output | 20 | Physical page number on hit, else zero |
| rsp_attr | output | 8 | Attribute bits on hit (bit 0 readable, bit 1 writable), else zero |
| fill_valid | input | 1 | Write a translation |
| fill_vpn | input | 20 | Virtual page number being filled |
| fill_ppn | input | 20 | Physical page number being filled |
| fill_attr | input | 8 | Attribute bits being filled |
| inv_valid | input | 1 | Invalidate one page |
| inv_vaddr | input | 32 | Full virtual address; only bits 31:12 select the page |
| flush | input | 1 | Invalidate every entry |

## Verification
Some properties can be checked on every cycle, and the assertions cover those. They check that a lookup is answered in the following cycle, that a miss drives zero data, and that no page ever matches two entries. They also check that the round-robin pointer moves only on a replacement or a flush, that a flush leaves nothing valid, and that a page invalidated and filled in the same cycle is absent afterwards. Other behaviour only shows up over a sequence of operations, and the bench scenarios cover it. That includes which entry a fill displaces when the store is full, the reuse of a freed slot before the pointer, and the reset of the pointer by a flush. It also includes the offset-blind match of an invalidate, range clearing by repeated page writes, and the lookup seeing contents from before a same-cycle update.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int XL_VA_W      = 32;
    localparam int XL_PA_W      = 32;
    localparam int XL_PAGE_BITS = 12;
    localparam int XL_ATTR_W    = 8;
    localparam int XL_DEPTH     = 16;

    // Where a fill lands
    typedef enum logic [1:0] {
        SLOT_SAME = 2'd0,   // entry already holding the page
        SLOT_FREE = 2'd1,   // lowest empty entry
        SLOT_RR   = 2'd2    // round-robin replacement
    } slot_src_e;

endpackage

// File: rtl/xlat_cam.sv
module xlat_cam #(
    parameter int DEPTH = 16,
    parameter int TAG_W = 20
) (
    input  logic [DEPTH-1:0]            valid,
    input  logic [DEPTH-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]            key,
    output logic [DEPTH-1:0]            match
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == key);
    end

endmodule

// File: rtl/xlat_rdmux.sv
module xlat_rdmux #(
    parameter int DEPTH = 16,
    parameter int W     = 20
) (
    input  logic [DEPTH-1:0]        sel,
    input  logic [DEPTH-1:0][W-1:0] data,
    output logic [W-1:0]            dout
);

    logic [DEPTH-1:0][W-1:0] gated;

    for (genvar g = 0; g < DEPTH; g++) begin : g_gate
        assign gated[g] = sel[g] ? data[g] : '0;
    end

    always_comb begin
        dout = '0;
        for (int i = 0; i < DEPTH; i++) begin
            dout = dout | gated[i];
        end
    end

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim
    import xlat_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input  logic [DEPTH-1:0] valid,
    input  logic [DEPTH-1:0] same_hit,
    input  logic [IDX_W-1:0] rr_ptr,
    output logic [IDX_W-1:0] slot_idx,
    output slot_src_e        slot_src
);

    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] same_idx;
    logic             any_free;

    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end

    always_comb begin
        same_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (same_hit[i]) begin
                same_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        if (|same_hit) begin
            slot_idx = same_idx;
            slot_src = SLOT_SAME;
        end else if (any_free) begin
            slot_idx = free_idx;
            slot_src = SLOT_FREE;
        end else begin
            slot_idx = rr_ptr;
            slot_src = SLOT_RR;
        end
    end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int VA_W      = XL_VA_W,
    parameter int PA_W      = XL_PA_W,
    parameter int PAGE_BITS = XL_PAGE_BITS,
    parameter int ATTR_W    = XL_ATTR_W,
    parameter int DEPTH     = XL_DEPTH
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      lk_valid,
    input  logic [VA_W-PAGE_BITS-1:0] lk_vpn,
    output logic                      rsp_valid,
    output logic                      rsp_hit,
    output logic [PA_W-PAGE_BITS-1:0] rsp_ppn,
    output logic [ATTR_W-1:0]         rsp_attr,
    input  logic                      fill_valid,
    input  logic [VA_W-PAGE_BITS-1:0] fill_vpn,
    input  logic [PA_W-PAGE_BITS-1:0] fill_ppn,
    input  logic [ATTR_W-1:0]         fill_attr,
    input  logic                      inv_valid,
    input  logic [VA_W-1:0]           inv_vaddr,
    input  logic                      flush
);

    localparam int VPN_W = VA_W - PAGE_BITS;
    localparam int PPN_W = PA_W - PAGE_BITS;
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0]             valid;
        logic [DEPTH-1:0][VPN_W-1:0]  tag;
        logic [DEPTH-1:0][PPN_W-1:0]  ppn;
        logic [DEPTH-1:0][ATTR_W-1:0] attr;
        logic [IDX_W-1:0]             rr;
        logic                         rsp_valid;
        logic                         rsp_hit;
        logic [PPN_W-1:0]             rsp_ppn;
        logic [ATTR_W-1:0]            rsp_attr;
    } state_t;

    state_t st_d, st_q;

    logic [VPN_W-1:0]  inv_vpn;
    logic [DEPTH-1:0]  lk_match;
    logic [DEPTH-1:0]  fill_match;
    logic [DEPTH-1:0]  inv_match;
    logic [PPN_W-1:0]  lk_ppn_sel;
    logic [ATTR_W-1:0] lk_attr_sel;
    logic [IDX_W-1:0]  slot_idx;
    slot_src_e         slot_src;
    logic              fill_take;
    logic              victim_taken;
    logic [DEPTH-1:0]  valid_vec;
    logic [IDX_W-1:0]  rr_ptr;

    assign inv_vpn   = inv_vaddr[VA_W-1:PAGE_BITS];
    assign valid_vec = st_q.valid;
    assign rr_ptr    = st_q.rr;

    xlat_cam #(.DEPTH(DEPTH), .TAG_W(VPN_W)) u_cam_lk (
        .valid (st_q.valid),
        .tags  (st_q.tag),
        .key   (lk_vpn),
        .match (lk_match)
    );

    xlat_cam #(.DEPTH(DEPTH), .TAG_W(VPN_W)) u_cam_fill (
        .valid (st_q.valid),
        .tags  (st_q.tag),
        .key   (fill_vpn),
        .match (fill_match)
    );

    xlat_cam #(.DEPTH(DEPTH), .TAG_W(VPN_W)) u_cam_inv (
        .valid (st_q.valid),
        .tags  (st_q.tag),
        .key   (inv_vpn),
        .match (inv_match)
    );

    xlat_rdmux #(.DEPTH(DEPTH), .W(PPN_W)) u_mux_ppn (
        .sel  (lk_match),
        .data (st_q.ppn),
        .dout (lk_ppn_sel)
    );

    xlat_rdmux #(.DEPTH(DEPTH), .W(ATTR_W)) u_mux_attr (
        .sel  (lk_match),
        .data (st_q.attr),
        .dout (lk_attr_sel)
    );

    xlat_victim #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_victim (
        .valid    (st_q.valid),
        .same_hit (fill_match),
        .rr_ptr   (st_q.rr),
        .slot_idx (slot_idx),
        .slot_src (slot_src)
    );

    // A fill is dropped by a flush or by an invalidate of its own page
    assign fill_take    = fill_valid && !flush && !(inv_valid && (inv_vpn == fill_vpn));
    assign victim_taken = fill_take && (slot_src == SLOT_RR);

    always_comb begin
        st_d = st_q;

        // lookup answers from the contents before this cycle's updates
        st_d.rsp_valid = lk_valid;
        st_d.rsp_hit   = lk_valid && (|lk_match);
        st_d.rsp_ppn   = lk_valid ? lk_ppn_sel : '0;
        st_d.rsp_attr  = lk_valid ? lk_attr_sel : '0;

        if (inv_valid) begin
            st_d.valid = st_d.valid & ~inv_match;
        end

        if (fill_take) begin
            st_d.valid[slot_idx] = 1'b1;
            st_d.tag[slot_idx]   = fill_vpn;
            st_d.ppn[slot_idx]   = fill_ppn;
            st_d.attr[slot_idx]  = fill_attr;
            if (slot_src == SLOT_RR) begin
                st_d.rr = (st_q.rr == LAST_IDX) ? '0 : st_q.rr + 1'b1;
            end
        end

        if (flush) begin
            st_d.valid = '0;
            st_d.rr    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_hit   = st_q.rsp_hit;
    assign rsp_ppn   = st_q.rsp_ppn;
    assign rsp_attr  = st_q.rsp_attr;

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
    parameter int DEPTH  = 16,
    parameter int VPN_W  = 20,
    parameter int PPN_W  = 20,
    parameter int ATTR_W = 8,
    parameter int IDX_W  = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      lk_valid,
    input logic                      rsp_valid,
    input logic                      rsp_hit,
    input logic [PPN_W-1:0]          rsp_ppn,
    input logic [ATTR_W-1:0]         rsp_attr,
    input logic                      fill_valid,
    input logic [VPN_W-1:0]          fill_vpn,
    input logic                      inv_valid,
    input logic [VPN_W-1:0]          inv_vpn,
    input logic                      flush,
    input logic [DEPTH-1:0]          valid_vec,
    input logic [DEPTH-1:0][VPN_W-1:0] tag_vec,
    input logic [DEPTH-1:0]          lk_match,
    input logic [DEPTH-1:0]          fill_match,
    input logic [IDX_W-1:0]          rr_ptr,
    input logic                      victim_taken
);

    logic [VPN_W-1:0] prev_fill_vpn;
    logic             prev_present;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_fill_vpn <= '0;
        end else begin
            prev_fill_vpn <= fill_vpn;
        end
    end

    always_comb begin
        prev_present = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (valid_vec[i] && (tag_vec[i] == prev_fill_vpn)) begin
                prev_present = 1'b1;
            end
        end
    end

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_vec == '0) && !rsp_valid);

    // R2
    rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    // R2
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_ppn == '0) && (rsp_attr == '0));

    // R3
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match) && $onehot0(fill_match));

    // R4
    rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!victim_taken && !flush) |=> $stable(rr_ptr));

    // R6
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0) && (rr_ptr == '0));

    // R7
    inv_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && fill_valid && (inv_vpn == fill_vpn)) |=> !prev_present);

endmodule

bind xlat_cache xlat_cache_chk #(
    .DEPTH  (DEPTH),
    .VPN_W  (VPN_W),
    .PPN_W  (PPN_W),
    .ATTR_W (ATTR_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_ppn      (rsp_ppn),
    .rsp_attr     (rsp_attr),
    .fill_valid   (fill_valid),
    .fill_vpn     (fill_vpn),
    .inv_valid    (inv_valid),
    .inv_vpn      (inv_vpn),
    .flush        (flush),
    .valid_vec    (valid_vec),
    .tag_vec      (st_q.tag),
    .lk_match     (lk_match),
    .fill_match   (fill_match),
    .rr_ptr       (rr_ptr),
    .victim_taken (victim_taken)
);

// File: tb/xlat_cache_test.sv
module xlat_cache_test;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [19:0] rsp_ppn;
    logic [7:0]  rsp_attr;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_ppn = '0;
    logic [7:0]  fill_attr = '0;
    logic        inv_valid = 1'b0;
    logic [31:0] inv_vaddr = '0;
    logic        flush = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    xlat_cache #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn), .rsp_attr(rsp_attr),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_attr(fill_attr),
        .inv_valid(inv_valid), .inv_vaddr(inv_vaddr), .flush(flush)
    );

    function automatic logic [19:0] ppn_of(input logic [19:0] v);
        return v ^ 20'h5A5A5;
    endfunction

    function automatic logic [7:0] attr_of(input logic [19:0] v);
        return v[7:0] ^ 8'h3C;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic look(input string req, input logic [19:0] v, input bit exp_hit,
                        input logic [19:0] exp_ppn, input logic [7:0] exp_attr);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vpn   = v;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(req, "rsp_valid", 32'(rsp_valid), 32'd1);
        chk(req, "rsp_hit", 32'(rsp_hit), 32'(exp_hit));
        chk(req, "rsp_ppn", 32'(rsp_ppn), exp_hit ? 32'(exp_ppn) : 32'd0);
        chk(req, "rsp_attr", 32'(rsp_attr), exp_hit ? 32'(exp_attr) : 32'd0);
    endtask

    task automatic expect_hit(input string req, input logic [19:0] v);
        look(req, v, 1'b1, ppn_of(v), attr_of(v));
    endtask

    task automatic expect_miss(input string req, input logic [19:0] v);
        look(req, v, 1'b0, '0, '0);
    endtask

    task automatic do_fill(input logic [19:0] v, input logic [19:0] p, input logic [7:0] a);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = v; fill_ppn = p; fill_attr = a;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic fill_std(input logic [19:0] v);
        do_fill(v, ppn_of(v), attr_of(v));
    endtask

    task automatic do_inv(input logic [31:0] va);
        @(negedge clk);
        inv_valid = 1'b1; inv_vaddr = va;
        @(negedge clk);
        inv_valid = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        expect_miss("R1", 20'h00000);
        expect_miss("R1", 20'h12345);
    endtask

    task automatic t_basic();
        fill_std(20'h00100);
        fill_std(20'h00200);
        fill_std(20'hFFFFF);
        expect_hit("R2", 20'h00100);
        expect_hit("R2", 20'hFFFFF);
        expect_miss("R2", 20'h00300);
        @(negedge clk);
        chk("R2", "rsp_valid idle", 32'(rsp_valid), 32'd0);
        // R11: attr bit 1 writable only, then bit 0 readable only
        do_fill(20'h00400, 20'h0ABCD, 8'h02);
        do_fill(20'h00401, 20'h0ABCE, 8'h01);
        look("R11", 20'h00400, 1'b1, 20'h0ABCD, 8'h02);
        look("R11", 20'h00401, 1'b1, 20'h0ABCE, 8'h01);
        do_flush();
    endtask

    task automatic t_refill();
        fill_std(20'h00700);
        do_fill(20'h00700, 20'h11111, 8'hA6);
        look("R3", 20'h00700, 1'b1, 20'h11111, 8'hA6);
        do_inv({20'h00700, 12'h000});
        expect_miss("R3", 20'h00700);
        do_flush();
    endtask

    task automatic t_roundrobin();
        for (int i = 0; i < DEPTH; i++) fill_std(20'h01000 + 20'(i));
        fill_std(20'h02000);                 // replaces slot 0
        expect_miss("R4", 20'h01000);
        expect_hit("R4", 20'h01001);
        expect_hit("R4", 20'h02000);
        fill_std(20'h02001);                 // replaces slot 1
        expect_miss("R4", 20'h01001);
        expect_hit("R4", 20'h01002);
        do_inv({20'h01007, 12'h000});        // frees slot 7
        fill_std(20'h03000);                 // goes to slot 7, pointer unchanged
        expect_hit("R4", 20'h01002);
        expect_hit("R4", 20'h01008);
        expect_hit("R4", 20'h03000);
        fill_std(20'h03001);                 // replaces slot 2
        expect_miss("R4", 20'h01002);
        expect_hit("R4", 20'h01003);
        do_flush();                          // pointer back to 0
        for (int i = 0; i < DEPTH; i++) fill_std(20'h04000 + 20'(i));
        fill_std(20'h05000);
        expect_miss("R4", 20'h04000);
        expect_hit("R4", 20'h04003);
        do_flush();
    endtask

    task automatic t_invalidate();
        fill_std(20'h0A000);
        fill_std(20'h0A001);
        do_inv({20'h0A000, 12'hFFF});
        expect_miss("R5", 20'h0A000);
        expect_hit("R5", 20'h0A001);
        do_inv({20'h0B000, 12'h123});
        expect_hit("R5", 20'h0A001);
        do_flush();
    endtask

    task automatic t_range();
        logic [31:0] start_va;
        logic [31:0] end_va;
        for (int i = 0; i < 6; i++) fill_std(20'h0C000 + 20'(i));
        start_va = {20'h0C001, 12'h000};
        end_va   = {20'h0C003, 12'hFFF};
        for (logic [31:0] a = start_va; a <= end_va; a += 32'h1000) do_inv(a);
        expect_hit("R10", 20'h0C000);
        expect_miss("R10", 20'h0C001);
        expect_miss("R10", 20'h0C002);
        expect_miss("R10", 20'h0C003);
        expect_hit("R10", 20'h0C004);
        expect_hit("R10", 20'h0C005);
        do_flush();
    endtask

    task automatic t_flush();
        for (int i = 0; i < 5; i++) fill_std(20'h0D000 + 20'(i * 3));
        do_flush();
        expect_miss("R6", 20'h0D000);
        expect_miss("R6", 20'h0D006);
        expect_miss("R6", 20'h0D00C);
    endtask

    task automatic t_collide();
        fill_std(20'h0E000);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = 20'h0E001; fill_ppn = ppn_of(20'h0E001); fill_attr = attr_of(20'h0E001);
        inv_valid = 1'b1; inv_vaddr = {20'h0E001, 12'h800};
        @(negedge clk);
        fill_valid = 1'b0; inv_valid = 1'b0;
        expect_miss("R7", 20'h0E001);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = 20'h0E002; fill_ppn = ppn_of(20'h0E002); fill_attr = attr_of(20'h0E002);
        inv_valid = 1'b1; inv_vaddr = {20'h0E000, 12'h000};
        @(negedge clk);
        fill_valid = 1'b0; inv_valid = 1'b0;
        expect_hit("R7", 20'h0E002);
        expect_miss("R7", 20'h0E000);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = 20'h0E003; fill_ppn = ppn_of(20'h0E003); fill_attr = attr_of(20'h0E003);
        flush = 1'b1;
        @(negedge clk);
        fill_valid = 1'b0; flush = 1'b0;
        expect_miss("R8", 20'h0E003);
        expect_miss("R8", 20'h0E002);
    endtask

    task automatic t_order();
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = 20'h0F000;
        fill_valid = 1'b1; fill_vpn = 20'h0F000; fill_ppn = ppn_of(20'h0F000); fill_attr = attr_of(20'h0F000);
        @(negedge clk);
        lk_valid = 1'b0; fill_valid = 1'b0;
        chk("R9", "hit during fill", 32'(rsp_hit), 32'd0);
        expect_hit("R9", 20'h0F000);
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = 20'h0F000;
        inv_valid = 1'b1; inv_vaddr = {20'h0F000, 12'h000};
        @(negedge clk);
        lk_valid = 1'b0; inv_valid = 1'b0;
        chk("R9", "hit during invalidate", 32'(rsp_hit), 32'd1);
        chk("R9", "ppn during invalidate", 32'(rsp_ppn), 32'(ppn_of(20'h0F000)));
        expect_miss("R9", 20'h0F000);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_refill();
        t_roundrobin();
        t_invalidate();
        t_range();
        t_flush();
        t_collide();
        t_order();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

endmodule